// File: doc/BRIEF.md
# Clock Generator Output-Enable Control

This block is the configuration register bank of a multi-output clock generator. A serial-bus slave drives its byte-wide register port. The block turns the stored settings into the enable lines for twelve differential outputs and four single-ended outputs. It also presents the spread-spectrum enable and the two frequency-margining select fields to the synthesis logic that sits next to it.

An active-low power-down pin can arrive at any time. It is resynchronised to the system clock first. While it is in effect, every enable is low and every register is held at its power-up value.

Two control bits in register 0 pick who owns the enables:
- the pin alone (hardware mode),
- nobody, which means a global software disable, or
- the individual enable bits (software mode).

Top module: `clkgen_oe_ctrl`

## Requirements
- R1: While the synchronised power-down level is low, every bit of `diff_oe` and `se_oe` is 0 and every register holds its power-up value.
- R2: The `pwrdn_n` pin passes through SYNC_STAGES flip-flops (default 2). With the default, a pin change shows on the enables after exactly two rising clock edges.
- R3: With register 0 bit 6 at 0 (hardware mode) and power-down released, all sixteen enables are 1 and the individual enable bits have no effect.
- R4: With register 0 bit 6 at 1 and bit 5 at 0, all sixteen enables are 0 regardless of the pin level.
- R5: With register 0 bits 6 and 5 both at 1, each enable follows its own bit. `diff_oe[11:7]` follows register 1 bits 4..0 and `diff_oe[6:0]` follows register 3 bits 7..1. `se_oe[3]`, `se_oe[2]` and `se_oe[1]` follow register 1 bits 7, 5 and 6, and `se_oe[0]` follows register 0 bit 0.
- R6: The power-up values are 0x35 for register 0, 0xF0 for register 1, 0x80 for register 2 and 0x06 for register 3. A write lands on the next rising edge. `reg_rdata` shows the addressed register combinationally.
- R7: Address 6 always reads 0x03: revision 0 in bits 7..4 and vendor 3 in bits 3..0. Writes to it are ignored.
- R8: Reserved locations read 0 and ignore writes. These are addresses 4, 5 and 7, register 2 bits 4..0 and register 3 bit 0.
- R9: `ssc_en` equals register 0 bit 7 (1 = -0.5% down-spread on the differential outputs). `freq_sel_lo` equals register 0 bits 4..1. `freq_sel_hi` equals register 2 bits 7..5.
- R10: A write issued while power-down is in effect or `rst_n` is low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down pin |
| reg_wr_en | input | 1 | Write strobe from the serial-bus slave |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| diff_oe | output | 12 | Differential output enables |
| se_oe | output | 4 | Single-ended output enables |
| ssc_en | output | 1 | Spread-spectrum enable |
| freq_sel_lo | output | 4 | 50 MHz margining select |
| freq_sel_hi | output | 3 | Selectable-output frequency select |

## Verification
The enable logic is driven through all three ownership modes, each with several enable-bit patterns. This shows whether the mode bits or the individual bits decide the outputs. Every bit is also checked against its mapped register position, which catches swapped or shifted positions.

The pin is toggled in each mode, including single-cycle low pulses. This separates a correct two-edge synchroniser and a full register reset from off-by-one latency or a partial reset. Writes are aimed at read-only bytes, reserved bits and a powered-down bank to show that they leave the read-back unchanged.

// File: rtl/clkgen_oe_pkg.sv
// Shared constants for the clock output-enable control block.
// Assumes a byte-wide register port with eight addressable locations.
package clkgen_oe_pkg;
    localparam int ADDR_W   = 3;
    localparam int NUM_CFG  = 4;
    localparam int CFG_IDXW = $clog2(NUM_CFG);
    localparam int NUM_DIFF = 12;
    localparam int NUM_SE   = 4;
    localparam int ID_ADDR  = 6;

    // Control bit positions inside register 0
    localparam int SSC_BIT  = 7;
    localparam int MODE_BIT = 6;
    localparam int GLOB_BIT = 5;

    // Power-up values, index 0 is register 0
    localparam logic [NUM_CFG-1:0][7:0] CFG_DEFAULT = {8'h06, 8'h80, 8'hF0, 8'h35};
    // Writable bit masks, index 0 is register 0
    localparam logic [NUM_CFG-1:0][7:0] CFG_WMASK   = {8'hFE, 8'hE0, 8'hFF, 8'hFF};

    typedef enum logic [1:0] {
        OWN_PIN  = 2'd0,
        OWN_NONE = 2'd1,
        OWN_BITS = 2'd2
    } oe_owner_e;
endpackage

// File: rtl/clkgen_pd_sync.sv
// Resynchronises the asynchronous power-down pin to clk.
// Assumes STAGES >= 2; reset drives the chain to the powered-down level.
module clkgen_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pd_ok
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
        end
    end

    assign pd_ok = chain_q[STAGES-1];
endmodule

// File: rtl/clkgen_cfg_regs.sv
// Register bank: writable bytes with per-bit masks, read-only ID byte,
// reserved locations returning zero.
// Assumes pd_ok is already synchronous to clk.
module clkgen_cfg_regs
    import clkgen_oe_pkg::*;
#(
    parameter logic [7:0] ID_BYTE = 8'h03
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pd_ok,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output logic [NUM_CFG-1:0][7:0]    cfg
);
    logic [NUM_CFG-1:0][7:0] cfg_q;
    logic                    in_cfg;

    assign in_cfg = (addr < ADDR_W'(NUM_CFG));

    // Hold defaults in reset or power-down, else merge masked write data
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_ok) begin
            cfg_q <= CFG_DEFAULT;
        end else if (wr_en && in_cfg) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (addr[CFG_IDXW-1:0] == CFG_IDXW'(i)) begin
                    cfg_q[i] <= (wdata & CFG_WMASK[i]) | (cfg_q[i] & ~CFG_WMASK[i]);
                end
            end
        end
    end

    // Select read data for the current address
    always_comb begin
        rdata = '0;
        if (in_cfg) begin
            rdata = cfg_q[addr[CFG_IDXW-1:0]];
        end else if (addr == ADDR_W'(ID_ADDR)) begin
            rdata = ID_BYTE;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/clkgen_oe_gate.sv
// Derives every output enable from the ownership mode, the
// synchronised power-down level and the individual enable bits.
// Assumes cfg holds registers 0..3.
module clkgen_oe_gate
    import clkgen_oe_pkg::*;
(
    input  logic                    pd_ok,
    input  logic [NUM_CFG-1:0][7:0] cfg,
    output logic [NUM_DIFF-1:0]     diff_oe,
    output logic [NUM_SE-1:0]       se_oe,
    output logic                    mode_sw,
    output logic                    sw_glob_en
);
    oe_owner_e owner;

    assign mode_sw    = cfg[0][MODE_BIT];
    assign sw_glob_en = cfg[0][GLOB_BIT];

    // Decode which agent owns the enables
    always_comb begin
        if (!mode_sw)         owner = OWN_PIN;
        else if (!sw_glob_en) owner = OWN_NONE;
        else                  owner = OWN_BITS;
    end

    // Produce enables, forced low while powered down
    always_comb begin
        diff_oe = '0;
        se_oe   = '0;
        if (pd_ok) begin
            case (owner)
                OWN_PIN: begin
                    diff_oe = '1;
                    se_oe   = '1;
                end
                OWN_BITS: begin
                    diff_oe = {cfg[1][4:0], cfg[3][7:1]};
                    se_oe   = {cfg[1][7], cfg[1][5], cfg[1][6], cfg[0][0]};
                end
                default: begin
                    diff_oe = '0;
                    se_oe   = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clkgen_oe_ctrl.sv
// Top: configuration registers and output-enable derivation for a
// multi-output clock generator. Assumes the serial-bus slave presents
// single-cycle write strobes synchronous to clk.
module clkgen_oe_ctrl
    import clkgen_oe_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REV_ID      = 4'h0,
    parameter logic [3:0] VENDOR_ID   = 4'h3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwrdn_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic [NUM_DIFF-1:0] diff_oe,
    output logic [NUM_SE-1:0]   se_oe,
    output logic                ssc_en,
    output logic [3:0]          freq_sel_lo,
    output logic [2:0]          freq_sel_hi
);
    localparam logic [7:0] ID_BYTE = {REV_ID, VENDOR_ID};

    logic                    pd_ok;
    logic                    mode_sw;
    logic                    sw_glob_en;
    logic [NUM_CFG-1:0][7:0] cfg;

    clkgen_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (pwrdn_n),
        .pd_ok (pd_ok)
    );

    clkgen_cfg_regs #(.ID_BYTE(ID_BYTE)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_ok (pd_ok),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    clkgen_oe_gate u_gate (
        .pd_ok      (pd_ok),
        .cfg        (cfg),
        .diff_oe    (diff_oe),
        .se_oe      (se_oe),
        .mode_sw    (mode_sw),
        .sw_glob_en (sw_glob_en)
    );

    assign ssc_en      = cfg[0][SSC_BIT];
    assign freq_sel_lo = cfg[0][4:1];
    assign freq_sel_hi = cfg[2][7:5];
endmodule

// File: rtl/clkgen_oe_ctrl_chk.sv
// Property checker for clkgen_oe_ctrl, attached by bind.
// Assumes the default ID byte 0x03 at address 6.
module clkgen_oe_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pd_ok,
    input logic        mode_sw,
    input logic        sw_glob_en,
    input logic        reg_wr_en,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_rdata,
    input logic [11:0] diff_oe,
    input logic [3:0]  se_oe,
    input logic        ssc_en,
    input logic [3:0]  freq_sel_lo,
    input logic [2:0]  freq_sel_hi
);
    // R1
    pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ok |-> (diff_oe == '0 && se_oe == '0));

    // R1
    pd_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ok |=> (!ssc_en && freq_sel_lo == 4'b1010 && freq_sel_hi == 3'b100));

    // R3
    hw_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_ok && !mode_sw) |-> (&diff_oe && &se_oe));

    // R4
    sw_global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sw && !sw_glob_en) |-> (diff_oe == '0 && se_oe == '0));

    // R7
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd6) |-> (reg_rdata == 8'h03));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4 || reg_addr == 3'd5 || reg_addr == 3'd7) |-> (reg_rdata == 8'h00));

    // R9
    ssc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ssc_en) |-> ($past(reg_wr_en && reg_addr == 3'd0) || $past(!pd_ok)));
endmodule

bind clkgen_oe_ctrl clkgen_oe_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_ok       (pd_ok),
    .mode_sw     (mode_sw),
    .sw_glob_en  (sw_glob_en),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .diff_oe     (diff_oe),
    .se_oe       (se_oe),
    .ssc_en      (ssc_en),
    .freq_sel_lo (freq_sel_lo),
    .freq_sel_hi (freq_sel_hi)
);

// File: tb/clkgen_oe_ctrl_bench.sv
// Bench: behavioural reference model updated on each rising edge and
// compared 2 ns later; directed checks for synchroniser latency and
// discarded writes.
module clkgen_oe_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [11:0] diff_oe;
    logic [3:0]  se_oe;
    logic        ssc_en;
    logic [3:0]  freq_sel_lo;
    logic [2:0]  freq_sel_hi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkgen_oe_ctrl u_clkgen_oe_ctrl (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .diff_oe(diff_oe), .se_oe(se_oe),
        .ssc_en(ssc_en), .freq_sel_lo(freq_sel_lo), .freq_sel_hi(freq_sel_hi)
    );

    // Reference model state
    int m_r[4];
    bit pdq[$];

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic load_defaults();
        // R6 power-up values
        m_r[0] = 'h35; m_r[1] = 'hF0; m_r[2] = 'h80; m_r[3] = 'h06;
    endtask

    // Model update at each edge, then compare every output
    always @(posedge clk) begin
        if (!rst_n) begin
            load_defaults();
            pdq = '{1'b0, 1'b0};
        end else begin
            if (!pdq[0]) load_defaults();
            else if (reg_wr_en) begin
                case (reg_addr)
                    3'd0: m_r[0] = int'(reg_wdata);
                    3'd1: m_r[1] = int'(reg_wdata);
                    3'd2: m_r[2] = int'(reg_wdata) & 'hE0;
                    3'd3: m_r[3] = int'(reg_wdata) & 'hFE;
                    default: ;
                endcase
            end
            // R2: two-entry pipeline for the pin level
            pdq.push_back(pwrdn_n);
            void'(pdq.pop_front());
        end
        #2;
        begin
            int  ed, es, er;
            bit  ok;
            string t;
            ok = pdq[0];
            ed = 0; es = 0;
            if (!ok) t = "R1";
            else if (((m_r[0] >> 6) & 1) == 0) begin t = "R3"; ed = 'hFFF; es = 'hF; end
            else if (((m_r[0] >> 5) & 1) == 0) t = "R4";
            else begin
                t = "R5";
                ed = ((m_r[1] & 'h1F) << 7) | ((m_r[3] >> 1) & 'h7F);
                es = (((m_r[1] >> 7) & 1) << 3) | (((m_r[1] >> 5) & 1) << 2)
                   | (((m_r[1] >> 6) & 1) << 1) | (m_r[0] & 1);
            end
            check(t, "diff_oe", int'(diff_oe), ed);
            check(t, "se_oe", int'(se_oe), es);
            check("R9", "ssc_en", int'(ssc_en), (m_r[0] >> 7) & 1);
            check("R9", "freq_sel_lo", int'(freq_sel_lo), (m_r[0] >> 1) & 'hF);
            check("R9", "freq_sel_hi", int'(freq_sel_hi), (m_r[2] >> 5) & 7);
            case (reg_addr)
                3'd6: begin er = 'h03; t = "R7"; end
                3'd4, 3'd5, 3'd7: begin er = 0; t = "R8"; end
                default: begin er = m_r[reg_addr]; t = "R6"; end
            endcase
            check(t, "reg_rdata", int'(reg_rdata), er);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            reg_addr = 3'(a);
        end
        @(negedge clk);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
        rd_all();                       // R6 defaults, R7 ID, R8 reserved
        wr(3'd1, 8'h00);                // R3 individual bits ignored
        wr(3'd3, 8'h00);
        cyc(2);
        wr(3'd6, 8'hFF);                // R7 write ignored
        wr(3'd4, 8'hFF);                // R8 write ignored
        wr(3'd5, 8'hAA);
        wr(3'd2, 8'hFF);                // R8 low bits stay 0, R9 fsel_hi
        wr(3'd3, 8'hFF);
        rd_all();
        // R2: pin drop reaches the enables after exactly two edges
        @(negedge clk);
        pwrdn_n = 1'b0;
        @(posedge clk); #3;
        check("R2", "diff_oe after 1 edge", int'(diff_oe), 'hFFF);
        @(posedge clk); #3;
        check("R2", "diff_oe after 2 edges", int'(diff_oe), 0);
        // R10: write during power-down discarded
        wr(3'd1, 8'h0F);
        @(negedge clk);
        pwrdn_n = 1'b1;
        cyc(3);
        reg_addr = 3'd1;
        @(posedge clk); #3;
        check("R10", "reg1 after pd write", int'(reg_rdata), 'hF0);
        // R5 software mode with several patterns
        wr(3'd0, 8'h75);
        wr(3'd1, 8'hA5);
        wr(3'd3, 8'h54);
        wr(3'd1, 8'h5A);
        wr(3'd3, 8'hAA);
        wr(3'd0, 8'h64);
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'hFE);
        wr(3'd0, 8'hE1);                // R9 spread on, fsel_lo 0
        rd_all();
        // R4 global software disable, pin toggled high stays off
        wr(3'd0, 8'h5F);
        cyc(3);
        wr(3'd0, 8'h40);
        cyc(3);
        // R1 single-cycle pin pulse resets bank from software mode
        wr(3'd0, 8'hFF);
        @(negedge clk);
        pwrdn_n = 1'b0;
        @(negedge clk);
        pwrdn_n = 1'b1;
        cyc(4);
        rd_all();
        // R10: write while rst_n low discarded
        @(negedge clk);
        rst_n = 1'b0; reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hC0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #3;
        check("R10", "reg0 after reset write", int'(reg_rdata), 'h35);
        cyc(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule